// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block chooses which of eight interrupt request lines should be granted next. A line is a candidate when its request bit is set and its mask bit is clear. The candidates are ranked in a circular order. That order starts at a programmable line, which ranks highest, and continues through the higher-numbered lines before wrapping back to line 0.

The in-service vector is ranked in the same circular order. A candidate is granted only when its rank is strictly better than the best in-service rank. This keeps a lower or equal priority source from interrupting a handler that is already running.

Two mode inputs can hide bits of the in-service vector from that comparison:
- A special-mask mode removes in-service bits whose mask bit is set.
- A special-fully-nested mode, active only when the block is the master, removes the in-service bit of the cascade line (line 2).

The block holds only one register, the rotation start. The grant, the line number and the interrupt output all follow combinationally from the inputs and that register. A controller around the block samples them to raise an interrupt, to acknowledge it, or to answer a poll.

Top module: `prio_resolver`

## Requirements
- R1: A line is a candidate only when its request bit is 1 and its mask bit is 0. With no candidate, win_valid and int_out are 0.
- R2: Candidates are ranked by circular distance upward from the rotation start (rank = (line - start) mod 8). Rank 0 is the highest priority, and the candidate with the lowest rank is chosen.
- R3: The rotation start is 0 after reset, so line 0 ranks highest. When rot_we is 1 at a rising clock edge, the start takes the value of rot_din.
- R4: The in-service vector is ranked in the same circular order, with an empty vector ranking below every line. The chosen candidate is granted only if its rank is strictly lower than the best in-service rank. An equal or higher rank gives no grant.
- R5: When smm_en is 1, in-service bits whose mask bit is 1 are left out of the comparison. When smm_en is 0, they take part.
- R6: When sfn_en and is_master are both 1, in-service bit 2 is left out of the comparison. Otherwise, it takes part.
- R7: When a grant exists, win_line gives its line number. When there is no grant, win_line is 0.
- R8: int_out equals win_valid.
- R9: The outputs follow changes of the vector and mode inputs within the same cycle, with no clock edge needed. A new rotation start affects the outputs from the edge that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the rotation-start register |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vec | input | 8 | Pending request bits, one per line |
| mask_vec | input | 8 | Mask bits, 1 blocks the line |
| svc_vec | input | 8 | In-service bits |
| rot_we | input | 1 | Load strobe for the rotation start |
| rot_din | input | 3 | New rotation start (the highest-ranked line) |
| smm_en | input | 1 | Special-mask mode |
| sfn_en | input | 1 | Special-fully-nested mode |
| is_master | input | 1 | 1 when this resolver is the master of a cascade |
| win_line | output | 3 | Granted line number, 0 when none |
| win_valid | output | 1 | A grant exists |
| int_out | output | 1 | Interrupt request output |

## Verification
The hardest case to reach is a comparison in which the wrap-around of the rotated order decides the result. This needs a candidate and an in-service line on opposite sides of the rotation start, so that their raw line numbers rank in the reverse order of their priorities. The directed tests first load a rotation start that places a high-numbered request ahead of a low-numbered in-service line, then one that does the reverse. A pseudo-random sweep then reloads the start often while drawing request, mask, in-service and mode patterns, so the wrap is crossed under every mode combination.

// File: rtl/prio_resolver.sv
`timescale 1ns/1ps
module prio_resolver #(
  parameter int LINES   = 8,
  parameter int CASCADE = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINES-1:0]           req_vec,
  input  logic [LINES-1:0]           mask_vec,
  input  logic [LINES-1:0]           svc_vec,
  input  logic                       rot_we,
  input  logic [$clog2(LINES)-1:0]   rot_din,
  input  logic                       smm_en,
  input  logic                       sfn_en,
  input  logic                       is_master,
  output logic [$clog2(LINES)-1:0]   win_line,
  output logic                       win_valid,
  output logic                       int_out
);
  localparam int LW = $clog2(LINES);
  localparam int RW = LW + 1;

  logic [LW-1:0]    rot_q;
  logic [LINES-1:0] cand;
  logic [LINES-1:0] svc_eff;
  logic [RW-1:0]    cand_rank;
  logic [RW-1:0]    svc_rank;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rot_q <= '0;
    else if (rot_we) rot_q <= rot_din;

  function automatic logic [RW-1:0] rank_of(input logic [LINES-1:0] v,
                                            input logic [LW-1:0] off);
    logic [RW-1:0] r;
    logic [LW-1:0] idx;
    r = RW'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      idx = off + LW'(k);
      if (v[idx]) r = RW'(k);
    end
    return r;
  endfunction

  assign cand = req_vec & ~mask_vec;

  always_comb begin
    svc_eff = svc_vec;
    if (smm_en) svc_eff = svc_eff & ~mask_vec;
    if (sfn_en && is_master) svc_eff[CASCADE] = 1'b0;
  end

  assign cand_rank = rank_of(cand, rot_q);
  assign svc_rank  = rank_of(svc_eff, rot_q);

  assign win_valid = cand_rank < svc_rank;
  assign win_line  = win_valid ? LW'(cand_rank[LW-1:0] + rot_q) : '0;
  assign int_out   = win_valid;
endmodule

// File: rtl/prio_resolver_chk.sv
`timescale 1ns/1ps
module prio_resolver_chk #(
  parameter int LINES   = 8,
  parameter int CASCADE = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LINES-1:0]         req_vec,
  input logic [LINES-1:0]         mask_vec,
  input logic [LINES-1:0]         svc_vec,
  input logic                     rot_we,
  input logic [$clog2(LINES)-1:0] rot_din,
  input logic                     sfn_en,
  input logic                     is_master,
  input logic [$clog2(LINES)-1:0] win_line,
  input logic                     win_valid,
  input logic                     int_out,
  input logic [$clog2(LINES)-1:0] rot_q
);
  // R1
  no_cand_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vec & ~mask_vec) == '0) |-> !int_out);

  // R7
  grant_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (req_vec[win_line] && !mask_vec[win_line]));

  // R7
  idle_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_line == '0));

  // R4
  not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !(sfn_en && is_master)) |-> !svc_vec[win_line]);

  // R3
  rot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_we |=> (rot_q == $past(rot_din)));
endmodule

bind prio_resolver prio_resolver_chk #(.LINES(LINES), .CASCADE(CASCADE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
  .svc_vec(svc_vec), .rot_we(rot_we), .rot_din(rot_din), .sfn_en(sfn_en),
  .is_master(is_master), .win_line(win_line), .win_valid(win_valid),
  .int_out(int_out), .rot_q(rot_q)
);

// File: tb/prio_resolver_bench.sv
`timescale 1ns/1ps
module prio_resolver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_vec = '0, mask_vec = '0, svc_vec = '0;
  logic       rot_we = 1'b0;
  logic [2:0] rot_din = '0;
  logic       smm_en = 1'b0, sfn_en = 1'b0, is_master = 1'b0;
  logic [2:0] win_line;
  logic       win_valid, int_out;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [2:0] exp_off = '0;

  always #2.5 clk = ~clk;

  prio_resolver u_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .svc_vec(svc_vec), .rot_we(rot_we), .rot_din(rot_din), .smm_en(smm_en),
    .sfn_en(sfn_en), .is_master(is_master), .win_line(win_line),
    .win_valid(win_valid), .int_out(int_out)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // expected outcome from the requirements: returns line, or -1 for none
  function automatic int model();
    int best_c = 8, best_s = 8;
    logic [7:0] s = svc_vec;
    if (smm_en) s = s & ~mask_vec;
    if (sfn_en && is_master) s[2] = 1'b0;
    for (int line = 0; line < 8; line++) begin
      int r = (line - int'(exp_off) + 8) % 8;
      if (req_vec[line] && !mask_vec[line] && r < best_c) best_c = r;
      if (s[line] && r < best_s) best_s = r;
    end
    if (best_c < best_s) return (best_c + int'(exp_off)) % 8;
    return -1;
  endfunction

  task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] sv,
                       input logic smm, input logic sfn, input logic mst);
    @(negedge clk);
    req_vec = rq; mask_vec = mk; svc_vec = sv;
    smm_en = smm; sfn_en = sfn; is_master = mst;
    #1;
  endtask

  task automatic expect_win(input string tag, input int line);
    check({tag, " valid"}, int'(win_valid), line >= 0 ? 1 : 0);
    check({tag, " line"},  int'(win_line),  line >= 0 ? line : 0);
    check({tag, " R8 int_out"}, int'(int_out), line >= 0 ? 1 : 0);
  endtask

  task automatic load_off(input logic [2:0] v);
    @(negedge clk);
    rot_we = 1'b1; rot_din = v;
    @(negedge clk);
    rot_we = 1'b0; rot_din = ~v;
    exp_off = v;
    #1;
  endtask

  task automatic t_reset();
    #1;
    expect_win("R1 in reset", -1);
    @(negedge clk); rst_n = 1'b1;
    apply(8'hFF, 8'h00, 8'h00, 0, 0, 0);
    expect_win("R3 start 0 after reset", 0);
  endtask

  task automatic t_mask();
    apply(8'h0C, 8'h04, 8'h00, 0, 0, 0);
    expect_win("R1 masked line skipped", 3);
    apply(8'h0C, 8'h0C, 8'h00, 0, 0, 0);
    expect_win("R1 all masked", -1);
    apply(8'h00, 8'h00, 8'hFF, 0, 0, 0);
    expect_win("R1 no request", -1);
  endtask

  task automatic t_rotate();
    for (int o = 0; o < 8; o++) begin
      load_off(3'(o));
      apply(8'hFF, 8'h00, 8'h00, 0, 0, 0);
      expect_win("R2 all pending at start", o);
      apply(8'h91, 8'h00, 8'h00, 0, 0, 0);
      expect_win("R2 R3 sparse after load", model());
    end
    load_off(3'd6);
    apply(8'h22, 8'h00, 8'h00, 0, 0, 0);
    expect_win("R2 wrap past line 7", 1);
  endtask

  task automatic t_nest();
    load_off(3'd0);
    apply(8'h04, 8'h00, 8'h08, 0, 0, 0);
    expect_win("R4 higher than in-service", 2);
    apply(8'h08, 8'h00, 8'h08, 0, 0, 0);
    expect_win("R4 equal to in-service", -1);
    apply(8'h10, 8'h00, 8'h08, 0, 0, 0);
    expect_win("R4 lower than in-service", -1);
    apply(8'h10, 8'h00, 8'h00, 0, 0, 0);
    expect_win("R4 empty in-service", 4);
    load_off(3'd5);
    apply(8'h80, 8'h00, 8'h02, 0, 0, 0);
    expect_win("R4 rotated wrap grant", 7);
    apply(8'h08, 8'h00, 8'h02, 0, 0, 0);
    expect_win("R4 rotated wrap block", -1);
  endtask

  task automatic t_smm();
    load_off(3'd0);
    apply(8'h20, 8'h02, 8'h02, 0, 0, 0);
    expect_win("R5 off keeps masked svc", -1);
    apply(8'h20, 8'h02, 8'h02, 1, 0, 0);
    expect_win("R5 on drops masked svc", 5);
    apply(8'h20, 8'h00, 8'h02, 1, 0, 0);
    expect_win("R5 unmasked svc still blocks", -1);
  endtask

  task automatic t_sfn();
    apply(8'h04, 8'h00, 8'h04, 0, 1, 1);
    expect_win("R6 master cascade renest", 2);
    apply(8'h08, 8'h00, 8'h04, 0, 1, 1);
    expect_win("R6 master lower line passes", 3);
    apply(8'h04, 8'h00, 8'h04, 0, 1, 0);
    expect_win("R6 slave keeps bit 2", -1);
    apply(8'h08, 8'h00, 8'h04, 0, 0, 1);
    expect_win("R6 mode off keeps bit 2", -1);
  endtask

  task automatic t_comb();
    @(negedge clk);
    req_vec = 8'h40; mask_vec = '0; svc_vec = '0;
    smm_en = 0; sfn_en = 0; is_master = 0;
    #0.5;
    expect_win("R9 immediate", 6);
    mask_vec = 8'h40;
    #0.5;
    expect_win("R9 same-cycle mask", -1);
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[3:0] == 4'h0) load_off(lf[10:8]);
      apply(lf[7:0], lf[15:8] & lf[23:16], lf[31:24] & lf[19:12],
            lf[4], lf[5], lf[6]);
      expect_win("R2 R4 R5 R6 sweep", model());
    end
  endtask

  initial begin
    t_reset();
    t_mask();
    t_rotate();
    t_nest();
    t_smm();
    t_sfn();
    t_comb();
    t_sweep();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule